// File: doc/BRIEF.md
# Overcurrent Fault Latch with Retry

This block decides whether a full-bridge motor driver may switch its output stage after a short circuit. An overcurrent detect line arrives from an analog comparator. The block counts how long the line stays high. It calls a fault only when the line has stayed high for a set number of clock cycles, so short glitches are ignored. When a fault is called, the block turns off the bridge-enable output and pulls an active-low fault flag low.

A strap input chooses what happens next. In timed retry mode the bridge stays off for a fixed timeout and is then switched back on, which tests whether the short is still there. In latch mode the bridge stays off until a standby-exit pulse or a power-on reset arrives. Undervoltage and over-temperature flags also turn off the bridge, but only while they are asserted. They never set the fault flag and are never latched.

The controller has three states:
- RUN: the bridge may be driven.
- RETRY_WAIT: a timed fault, bridge off.
- LATCHED: a held fault, bridge off.

It has these transitions:
- RUN to RETRY_WAIT on a qualified overcurrent in retry mode.
- RUN to LATCHED on a qualified overcurrent in latch mode.
- RETRY_WAIT to RUN when the timeout ends.
- RETRY_WAIT to RUN on a standby-exit pulse.
- LATCHED to RUN on a standby-exit pulse.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: A fault is qualified only when `oc_detect_i` is sampled high on QUAL_CYCLES consecutive rising edges while in RUN. A high pulse of QUAL_CYCLES-1 edges, followed by a low sample, causes no fault and resets the count.
- R2: On the edge that qualifies a fault, `fault_n_o` goes to 0 and `bridge_en_o` goes to 0.
- R3: When `latch_mode_i` = 0 is sampled on the qualifying edge, the bridge stays off for exactly RETRY_CYCLES edges. On that edge both `bridge_en_o` and `fault_n_o` return to 1.
- R4: When `latch_mode_i` = 1 is sampled on the qualifying edge, `fault_n_o` = 0 and `bridge_en_o` = 0 hold with no time limit until a standby exit or a reset.
- R5: A one-cycle `standby_exit_i` = 1 pulse while a fault is held returns the block to RUN on the next edge, with `fault_n_o` = 1. This applies in either fault state.
- R6: `standby_exit_i` has no effect while no fault is held.
- R7: While `uv_i` = 1 or `ot_i` = 1, `bridge_en_o` = 0 without a clock edge, and `fault_n_o` is unaffected. When both flags clear, the bridge is enabled again, with no latching.
- R8: If the overcurrent persists after a retry re-enables the bridge, the fault qualifies again QUAL_CYCLES edges later and starts a full new timeout.
- R9: `latch_mode_i` is sampled only at qualification. Changing it while a fault is held has no effect.
- R10: While `rst_n` = 0, and after its release, the block is in RUN with `fault_n_o` = 1. A reset also clears a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| oc_detect_i | input | 1 | Raw overcurrent comparator output |
| latch_mode_i | input | 1 | Strap input: 1 selects latch mode, 0 selects timed retry |
| standby_exit_i | input | 1 | One-cycle pulse when the driver leaves standby |
| uv_i | input | 1 | Undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| bridge_en_o | output | 1 | 1 allows the bridge to be driven |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
The hardest situation to reach is a short that is still present when a retry turns the bridge back on. Reaching it needs the overcurrent to be held through a full timeout. The stimulus must then confirm two things: that the fault qualifies again after the full filter length rather than at once, and that the second timeout runs its full length. The directed task therefore holds `oc_detect_i` high across two complete qualify-and-wait periods, and counts edges from the release edge.

A second hard case is changing the mode strap while a fault is held. Reaching it needs a retry fault to be entered first. The stimulus flips the strap in the middle of the timeout and checks that the timeout still ends on schedule.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_RETRY_WAIT = 2'd1,
        ST_LATCHED    = 2'd2
    } ocp_state_e;

endpackage

// File: rtl/ocp_pw_filter.sv
// Pulse-width qualifier: flags an overcurrent once the detect line has
// been high for QUAL_CYCLES consecutive edges while armed.
module ocp_pw_filter #(
    parameter int QUAL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic oc_i,
    output logic qual_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm_i || !oc_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qual_o = arm_i && oc_i && (cnt_q == LAST);

endmodule

// File: rtl/ocp_retry_timer.sv
// Timeout counter: done_o is high on the RETRY_CYCLES-th edge of a run.
module ocp_retry_timer #(
    parameter int RETRY_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int TW = $clog2(RETRY_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(RETRY_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/ocp_fault_fsm.sv
module ocp_fault_fsm
    import ocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qual_i,
    input  logic       timer_done_i,
    input  logic       latch_mode_i,
    input  logic       standby_exit_i,
    output ocp_state_e state_o,
    output logic       fault_n_o
);
    ocp_state_e st_q, st_nxt;

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (qual_i) begin
                    st_nxt = latch_mode_i ? ST_LATCHED : ST_RETRY_WAIT;
                end
            end
            ST_RETRY_WAIT: begin
                if (standby_exit_i || timer_done_i) begin
                    st_nxt = ST_RUN;
                end
            end
            ST_LATCHED: begin
                if (standby_exit_i) begin
                    st_nxt = ST_RUN;
                end
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_n_o <= 1'b1;
        end else begin
            fault_n_o <= (st_nxt == ST_RUN);
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
    import ocp_pkg::*;
#(
    parameter int QUAL_CYCLES  = 8,
    parameter int RETRY_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_detect_i,
    input  logic latch_mode_i,
    input  logic standby_exit_i,
    input  logic uv_i,
    input  logic ot_i,
    output logic bridge_en_o,
    output logic fault_n_o
);
    ocp_state_e st_q;
    logic       qual;
    logic       timer_done;

    ocp_pw_filter #(.QUAL_CYCLES(QUAL_CYCLES)) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (st_q == ST_RUN),
        .oc_i   (oc_detect_i),
        .qual_o (qual)
    );

    ocp_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q == ST_RETRY_WAIT),
        .done_o (timer_done)
    );

    ocp_fault_fsm fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .qual_i         (qual),
        .timer_done_i   (timer_done),
        .latch_mode_i   (latch_mode_i),
        .standby_exit_i (standby_exit_i),
        .state_o        (st_q),
        .fault_n_o      (fault_n_o)
    );

    // thermal and supply gating act directly, never latched
    assign bridge_en_o = (st_q == ST_RUN) && !uv_i && !ot_i;

endmodule

// File: rtl/ocp_fault_ctrl_chk.sv
module ocp_fault_ctrl_chk
    import ocp_pkg::*;
#(
    parameter int RETRY_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       oc_detect_i,
    input logic       standby_exit_i,
    input logic       uv_i,
    input logic       ot_i,
    input logic       bridge_en_o,
    input logic       fault_n_o,
    input ocp_state_e st
);
    localparam int WW = $clog2(RETRY_CYCLES + 2);

    logic [WW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (st == ST_RETRY_WAIT) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    assert_qual_needs_oc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> $past(oc_detect_i));

    assert_fault_blocks_bridge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> !bridge_en_o);

    assert_retry_duration_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_n_o) && !$past(standby_exit_i)) |-> (wait_cnt == WW'(RETRY_CYCLES)));

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCHED && !standby_exit_i) |=> (st == ST_LATCHED));

    assert_standby_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n_o && standby_exit_i) |=> fault_n_o);

    assert_env_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_i || ot_i) |-> !bridge_en_o);

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETRY_WAIT) |=> (st != ST_LATCHED));

endmodule

bind ocp_fault_ctrl ocp_fault_ctrl_chk #(.RETRY_CYCLES(RETRY_CYCLES)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .oc_detect_i    (oc_detect_i),
    .standby_exit_i (standby_exit_i),
    .uv_i           (uv_i),
    .ot_i           (ot_i),
    .bridge_en_o    (bridge_en_o),
    .fault_n_o      (fault_n_o),
    .st             (st_q)
);

// File: tb/ocp_fault_ctrl_tb_top.sv
module ocp_fault_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL  = 8;
    localparam int RETRY = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0, latch_mode = 1'b0, sb_exit = 1'b0, uv = 1'b0, ot = 1'b0;
    logic bridge_en, fault_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_fault_ctrl #(.QUAL_CYCLES(QUAL), .RETRY_CYCLES(RETRY)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .oc_detect_i    (oc),
        .latch_mode_i   (latch_mode),
        .standby_exit_i (sb_exit),
        .uv_i           (uv),
        .ot_i           (ot),
        .bridge_en_o    (bridge_en),
        .fault_n_o      (fault_n)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_exit();
        sb_exit = 1'b1;
        tick(1);
        sb_exit = 1'b0;
    endtask

    // oc is raised at a negedge; the fault lands on the QUAL-th edge after
    task automatic raise_to_fault(string tag);
        oc = 1'b1;
        tick(QUAL - 1);
        chk({tag, " pre-qual bridge"}, bridge_en, 1'b1);
        tick(1);
        chk({tag, " fault_n low"}, fault_n, 1'b0);
        chk({tag, " bridge off"}, bridge_en, 1'b0);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R10 reset fault_n", fault_n, 1'b1);
        chk("R10 reset bridge", bridge_en, 1'b1);
        rst_n = 1'b1;
        tick(2);
        chk("R10 after release", fault_n, 1'b1);
    endtask

    task automatic t_short_pulse();
        oc = 1'b1;
        tick(QUAL - 1);
        oc = 1'b0;
        tick(1);
        oc = 1'b1;
        tick(QUAL - 1);
        oc = 1'b0;
        tick(3);
        chk("R1 short pulses ignored fault_n", fault_n, 1'b1);
        chk("R1 short pulses ignored bridge", bridge_en, 1'b1);
    endtask

    task automatic t_retry();
        latch_mode = 1'b0;
        raise_to_fault("R1 R2 retry");
        oc = 1'b0;
        tick(RETRY - 1);
        chk("R3 still off before timeout", bridge_en, 1'b0);
        tick(1);
        chk("R3 bridge back on", bridge_en, 1'b1);
        chk("R3 fault_n back high", fault_n, 1'b1);
    endtask

    task automatic t_persist();
        latch_mode = 1'b0;
        raise_to_fault("R8 first");
        tick(RETRY);
        chk("R8 re-enabled", bridge_en, 1'b1);
        tick(QUAL - 1);
        chk("R8 not yet requalified", fault_n, 1'b1);
        tick(1);
        chk("R8 requalified", fault_n, 1'b0);
        oc = 1'b0;
        tick(RETRY - 1);
        chk("R8 full second timeout", fault_n, 1'b0);
        tick(1);
        chk("R8 second release", fault_n, 1'b1);
    endtask

    task automatic t_latch();
        latch_mode = 1'b1;
        raise_to_fault("R4 latch");
        oc = 1'b0;
        tick(RETRY + 50);
        chk("R4 still latched fault_n", fault_n, 1'b0);
        chk("R4 still latched bridge", bridge_en, 1'b0);
        latch_mode = 1'b0;
        tick(5);
        chk("R9 strap change ignored while latched", fault_n, 1'b0);
        pulse_exit();
        chk("R5 exit clears latch", fault_n, 1'b1);
        chk("R5 exit enables bridge", bridge_en, 1'b1);
    endtask

    task automatic t_exit_in_retry();
        latch_mode = 1'b0;
        raise_to_fault("R5 retry");
        oc = 1'b0;
        tick(10);
        pulse_exit();
        chk("R5 exit clears retry wait", fault_n, 1'b1);
    endtask

    task automatic t_mode_change();
        latch_mode = 1'b0;
        raise_to_fault("R9 retry");
        oc = 1'b0;
        tick(20);
        latch_mode = 1'b1;
        tick(RETRY - 20);
        chk("R9 timeout still ends", fault_n, 1'b1);
        latch_mode = 1'b0;
    endtask

    task automatic t_exit_idle();
        pulse_exit();
        chk("R6 idle exit fault_n", fault_n, 1'b1);
        chk("R6 idle exit bridge", bridge_en, 1'b1);
    endtask

    task automatic t_env();
        uv = 1'b1;
        #1;
        chk("R7 uv gates bridge", bridge_en, 1'b0);
        tick(3);
        chk("R7 uv leaves fault_n", fault_n, 1'b1);
        uv = 1'b0;
        #1;
        chk("R7 uv release", bridge_en, 1'b1);
        ot = 1'b1;
        #1;
        chk("R7 ot gates bridge", bridge_en, 1'b0);
        tick(2);
        ot = 1'b0;
        #1;
        chk("R7 ot release", bridge_en, 1'b1);
        tick(1);
    endtask

    task automatic t_por_clear();
        latch_mode = 1'b1;
        raise_to_fault("R10 latch");
        oc = 1'b0;
        latch_mode = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R10 reset clears latch", fault_n, 1'b1);
        tick(2);
        rst_n = 1'b1;
        tick(2);
        chk("R10 bridge after reset", bridge_en, 1'b1);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_short_pulse();
        t_retry();
        t_persist();
        t_latch();
        t_exit_in_retry();
        t_mode_change();
        t_exit_idle();
        t_env();
        t_por_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule